// File: doc/BRIEF.md
# Serial Output-Enable Controller for a Clock Fanout Buffer

This block is a receive-only two-wire serial (I2C) slave that sets the output enables of a ten-pair differential clock fanout buffer. A system clock oversamples the SCL and SDA lines. The block finds START and STOP conditions and matches a fixed 7-bit device address with the write direction bit. It acknowledges the address and the first two data bytes. The data bytes load two 8-bit enable registers.

There is no register pointer. After every START, the first data byte goes to enable register 0 and the second goes to enable register 1. Any further bytes are refused. Each of the ten enable outputs drives the tri-state control of one clock pair. A high level lets the pair drive. A low level puts the pair in high impedance. After reset every pair is enabled.

The slave never returns data. It pulls SDA low only to acknowledge.

Top module: `clk_oe_i2c_ctrl`

## Requirements
- R1: After reset, all ten `oe_o` bits are 1 and `sda_oe_o` is 0.
- R2: An address byte whose upper seven bits equal `DEV_ADDR` and whose bit 0 (direction) is 0 is acknowledged: `sda_oe_o` is 1 while SCL is high in the ninth clock.
- R3: `oe_o[k]` equals bit k of register 0 for k in 0..7. `oe_o[8]` and `oe_o[9]` equal bits 0 and 1 of register 1. A 0 disables the pair and a 1 enables it.
- R4: After each START, the first data byte is written to register 0 and the second to register 1. Both are acknowledged.
- R5: If the address does not match, or the direction bit is 1, there is no acknowledge. No register changes until the next START.
- R6: Data bytes after the second byte of a transaction are not acknowledged and change no register.
- R7: `sda_oe_o` rises only while SCL is low, and it is 1 only in an acknowledge phase.
- R8: A STOP or repeated START inside a byte leaves the target register unchanged. The next data byte goes to register 0.
- R9: Bits 2..7 of register 1 drive no output. Writing any value to them leaves `oe_o[9:8]` set by bits 1..0 only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| oe_o | output | 10 | Per-pair clock output enables, 1 = drive |

## Verification
The bench aborts a byte halfway with a STOP and, in another test, with a repeated START. A design that commits shifted bits early, or keeps its byte position across the abort, would corrupt a register or write the next byte into register 1. The bench sends a third data byte and expects no acknowledge and no change; a pointer that wraps would overwrite register 0. It also sends a wrong address and a read-direction address, each followed by data, where any acknowledge or enable change is an error. Writes to register 1 with the upper bits both set and cleared show whether unused bits leak into the top enables.

// File: rtl/clk_oe_pkg.sv
package clk_oe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK,
    ST_IGNORE
  } rx_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  // idle bus is high: reset synchronizers to 1 so no false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import clk_oe_pkg::*;
#(
  parameter int          ADDR_W   = 7,
  parameter logic [6:0]  DEV_ADDR = 7'h6A,
  parameter int          NUM_REGS = 2,
  parameter int          REG_W    = 8,
  localparam int         IDX_W    = $clog2(NUM_REGS + 1),
  localparam int         CNT_W    = $clog2(REG_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [REG_W-1:0] wr_data_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(REG_W - 1);
  localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(NUM_REGS);

  rx_state_e        state_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic [REG_W-1:0] shreg_q;
  logic [IDX_W-1:0] byte_idx_q;
  logic             full_q, ack_pend_q, sda_oe_q;
  logic             wr_en_q;
  logic [IDX_W-1:0] wr_idx_q;
  logic [REG_W-1:0] wr_data_q;
  logic [REG_W-1:0] byte_now;
  logic             last_rise;

  assign byte_now  = {shreg_q[REG_W-2:0], sda_i};
  assign last_rise = scl_rise_i && (bit_cnt_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      byte_idx_q <= '0;
      full_q     <= 1'b0;
      ack_pend_q <= 1'b0;
      sda_oe_q   <= 1'b0;
      wr_en_q    <= 1'b0;
      wr_idx_q   <= '0;
      wr_data_q  <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        state_q    <= ST_ADDR;
        bit_cnt_q  <= '0;
        byte_idx_q <= '0;
        full_q     <= 1'b0;
        sda_oe_q   <= 1'b0;
      end else if (stop_i) begin
        state_q    <= ST_IDLE;
        bit_cnt_q  <= '0;
        byte_idx_q <= '0;
        full_q     <= 1'b0;
        sda_oe_q   <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_DATA: begin
            if (scl_rise_i && !full_q) begin
              shreg_q   <= byte_now;
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            if (last_rise && !full_q) begin
              full_q    <= 1'b1;
              bit_cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                ack_pend_q <= (byte_now[REG_W-1 -: ADDR_W] == DEV_ADDR) && !byte_now[0];
              end else if (byte_idx_q < IDX_END) begin
                // byte is complete: commit now
                wr_en_q    <= 1'b1;
                wr_idx_q   <= byte_idx_q;
                wr_data_q  <= byte_now;
                byte_idx_q <= byte_idx_q + 1'b1;
                ack_pend_q <= 1'b1;
              end else begin
                ack_pend_q <= 1'b0;
              end
            end
            if (scl_fall_i && full_q) begin
              full_q <= 1'b0;
              if (state_q == ST_ADDR && !ack_pend_q) begin
                state_q <= ST_IGNORE;
              end else begin
                state_q  <= ST_ACK;
                sda_oe_q <= ack_pend_q;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              sda_oe_q  <= 1'b0;
              state_q   <= ST_DATA;
              bit_cnt_q <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = sda_oe_q;
  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;

  AST_DRIVE_ONLY_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_q |-> state_q == ST_ACK);  // R7
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_q) |-> !scl_i);  // R7
  AST_IGNORE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IGNORE |-> !wr_en_q && !sda_oe_q);  // R5
  AST_WR_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> wr_idx_q < IDX_END);  // R6
endmodule

// File: rtl/oe_reg_bank.sv
module oe_reg_bank #(
  parameter int  NUM_REGS = 2,
  parameter int  REG_W    = 8,
  parameter int  NUM_OUT  = 10,
  localparam int IDX_W    = $clog2(NUM_REGS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic [NUM_OUT-1:0] oe_o
);
  // only bits that reach an output are stored; the rest are discarded on write
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_bit
    localparam logic [IDX_W-1:0] REG_SEL = IDX_W'(k / REG_W);
    localparam int               BIT_SEL = k % REG_W;
    logic en_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             en_q <= 1'b1;
      else if (wr_en_i && wr_idx_i == REG_SEL) en_q <= wr_data_i[BIT_SEL];
    end

    assign oe_o[k] = en_q;

    AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_idx_i == REG_SEL) |=> $stable(oe_o[k]));  // R8
  end
endmodule

// File: rtl/clk_oe_i2c_ctrl.sv
module clk_oe_i2c_ctrl #(
  parameter logic [6:0] DEV_ADDR = 7'h6A,
  parameter int         NUM_OUT  = 10,
  parameter int         REG_W    = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        NUM_REGS = (NUM_OUT + REG_W - 1) / REG_W,
  localparam int        IDX_W    = $clog2(NUM_REGS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [NUM_OUT-1:0] oe_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [REG_W-1:0] wr_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_slave_rx #(
    .ADDR_W(7), .DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .REG_W(REG_W)
  ) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop),
    .sda_oe_o(sda_oe_o), .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  oe_reg_bank #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .NUM_OUT(NUM_OUT)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .oe_o(oe_o)
  );
endmodule

// File: tb/clk_oe_i2c_ctrl_test.sv
module clk_oe_i2c_ctrl_test;
  localparam logic [6:0] ADDR = 7'h6A;
  localparam int Q = 12;

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  logic sda_oe;
  logic [9:0] oe;
  logic sda_bus;
  int checks = 0, errors = 0, cyc = 0;
  logic [9:0] exp_oe;

  assign sda_bus = sda_m & ~sda_oe;

  clk_oe_i2c_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .oe_o(oe)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wq(int n); repeat (n) @(posedge clk); #1; endtask

  task automatic chk(string req, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_start(); sda_m = 1; scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q); endtask
  task automatic bus_rstart(); sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q); endtask
  task automatic bus_stop(); sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(4*Q); endtask

  task automatic send_bit(logic b);
    sda_m = b; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1; wq(Q); scl_m = 1; wq(Q);
    ack = ~sda_bus;
    wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic chk_ack(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s ack actual %0b expected %0b", req, act, exp);
    end
  endtask

  // full write transaction; acks checked against the R2/R4/R5/R6 rules
  task automatic xfer(logic [6:0] a, logic rw, int n, logic [7:0] d0, logic [7:0] d1, logic [7:0] d2);
    logic ack;
    logic [7:0] d [3];
    logic ok;
    d[0] = d0; d[1] = d1; d[2] = d2;
    ok = (a == ADDR) && !rw;
    bus_start();
    send_byte({a, rw}, ack);
    chk_ack(ok ? "R2" : "R5", ack, ok);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ack);
      chk_ack(i < 2 ? "R4" : "R6", ack, ok && i < 2);
      if (ok && i == 0) exp_oe[7:0] = d[i];
      if (ok && i == 1) exp_oe[9:8] = d[i][1:0];
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 oe", oe, 10'h3FF);
    chk("R1 sda_oe", {9'b0, sda_oe}, 10'h0);
  endtask

  task automatic t_basic();
    xfer(ADDR, 0, 2, 8'h5A, 8'h02, 8'h00);
    chk("R3 mapping", oe, exp_oe);
    xfer(ADDR, 0, 2, 8'h00, 8'h00, 8'h00);
    chk("R3 all off", oe, 10'h000);
    xfer(ADDR, 0, 2, 8'hA5, 8'h01, 8'h00);
    chk("R4 both regs", oe, 10'h1A5);
  endtask

  task automatic t_bad_addr();
    xfer(ADDR ^ 7'h01, 0, 2, 8'h00, 8'h00, 8'h00);
    chk("R5 wrong addr", oe, exp_oe);
    xfer(ADDR, 1, 2, 8'h33, 8'h00, 8'h00);
    chk("R5 read dir", oe, exp_oe);
  endtask

  task automatic t_third();
    xfer(ADDR, 0, 3, 8'hF0, 8'h03, 8'h0F);
    chk("R6 third byte", oe, 10'h3F0);
  endtask

  task automatic t_one_byte();
    xfer(ADDR, 0, 1, 8'h11, 8'h00, 8'h00);
    chk("R4 single byte reg0 only", oe, 10'h311);
  endtask

  task automatic t_abort_stop();
    logic ack;
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    chk_ack("R8", ack, 1'b1);
    send_byte(8'h22, ack);
    send_bit(0); send_bit(0); send_bit(0); send_bit(0);
    bus_stop();
    chk("R8 stop mid-byte", oe, 10'h322);
    xfer(ADDR, 0, 1, 8'h44, 8'h00, 8'h00);
    chk("R8 restart at reg0", oe, 10'h344);
  endtask

  task automatic t_abort_rstart();
    logic ack;
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    send_bit(0); send_bit(1); send_bit(0);
    bus_rstart();
    send_byte({ADDR, 1'b0}, ack);
    chk_ack("R8 rstart addr", ack, 1'b1);
    send_byte(8'h66, ack);
    bus_stop();
    exp_oe[7:0] = 8'h66;
    chk("R8 rstart to reg0", oe, exp_oe);
  endtask

  task automatic t_unused();
    xfer(ADDR, 0, 2, 8'h66, 8'hFC, 8'h00);
    chk("R9 upper ones", oe, 10'h066);
    xfer(ADDR, 0, 2, 8'h66, 8'h03, 8'h00);
    chk("R9 upper zeros", oe, 10'h366);
  endtask

  task automatic t_idle_release();
    chk("R7 released idle", {9'b0, sda_oe}, 10'h0);
  endtask

  initial begin
    exp_oe = 10'h3FF;
    wq(5);
    t_reset();
    rst_n = 1;
    wq(10);
    t_reset();
    t_basic();
    t_bad_addr();
    t_third();
    t_one_byte();
    t_abort_stop();
    t_abort_rstart();
    t_unused();
    t_idle_release();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule